// File: doc/BRIEF.md
# Dynamic-Sign Multiplier with Fixed-Point Round and Saturate

This block multiplies two 18-bit operands. Two sign-select inputs give the signedness of each operand, one for A and one for B. They may change on any cycle, so one operand pair can be unsigned×unsigned, the next signed×signed, and the next mixed. The full product is 36 bits wide.

The operand stage and the result stage can each be built as a register or as a wire, using two parameters. Each register stage has its own clock enable and its own asynchronous clear. The sign selects and the round and saturate controls travel through the operand stage with the data. Each control therefore acts on the operands sampled in the same cycle.

When both operands are signed and either fixed-point control is high, the block works in fractional mode. The operands are read as Q1.15 values sign-extended to 18 bits, and the Q2.30 product is reduced to a 16-bit Q1.15 result. Rounding and clamping are optional in this mode. A saturation flag leaves the block with the same delay as the result it describes.

Operating modes, chosen per operand pair:
- UNS: both operands unsigned.
- MIXED: exactly one operand signed.
- SGN: both operands signed, with no fixed-point control high.
- FRAC: both operands signed, with a fixed-point control high.

The mode is a pure function of the registered controls and has no transitions of its own.

Top module: `dynsign_mult`

## Requirements
- R1: With both sign selects low (mode UNS), `prod` is the unsigned 36-bit product of the two 18-bit operands.
- R2: An operand whose sign select is high is read as two's complement, with bit 17 as its sign. In modes MIXED and SGN, `prod` is the 36-bit two's-complement product.
- R3: The sign selects and the round and saturate controls are staged with the operands. Each acts on the operand pair presented in the same cycle. Latency is IN_REG+OUT_REG cycles, which is 2 by default and 0 when both stages are wires. `sat_flag` has the same latency as `prod`.
- R4: While `in_en` is low, the operand stage holds its contents. While `out_en` is low, `prod` and `sat_flag` hold their values.
- R5: `in_clr` clears the operand stage to zero and `out_clr` clears `prod` and `sat_flag` to zero. Both act at once, without a clock edge.
- R6: Mode FRAC applies when both sign selects are high and `rnd_en` or `sat_en` is high. In this mode the result is bits [30:15] of the product, after any rounding, sign-extended to 36 bits.
- R7: With `rnd_en` high in mode FRAC, 0x4000 (half of one result LSB) is added to the product before truncation.
- R8: With `sat_en` high in mode FRAC, a result above 0x7FFF is clamped to 0x7FFF and a result below -0x8000 is clamped to 0x8000, each sign-extended. `sat_flag` is high only for an output that was clamped.
- R9: Outside mode FRAC, `rnd_en` and `sat_en` have no effect on `prod`, and `sat_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| in_clr | input | 1 | Asynchronous clear of the operand stage |
| in_en | input | 1 | Clock enable of the operand stage |
| out_clr | input | 1 | Asynchronous clear of the result stage |
| out_en | input | 1 | Clock enable of the result stage |
| op_a | input | 18 | Operand A |
| op_b | input | 18 | Operand B |
| a_signed | input | 1 | Operand A is two's complement |
| b_signed | input | 1 | Operand B is two's complement |
| rnd_en | input | 1 | Round the fractional result |
| sat_en | input | 1 | Saturate the fractional result |
| prod | output | 36 | Product, or the sign-extended Q1.15 result in mode FRAC |
| sat_flag | output | 1 | The output in `prod` was clamped |

## Verification
The checks on a clamped output and on a sign-extended fractional result assume the following about the inputs:
- Both clears are raised before the first clock edge.
- A clear is never pulsed between two edges while the result enable is low.

The stimulus holds both clears high from time zero. It pulses them only with `out_en` high.

A scoreboard predicts every operand pair from the requirements alone. It switches signedness and the fixed-point controls on consecutive cycles, so that a control applied to the wrong operand pair would show up as a mismatch. A second instance built with both stages as wires is checked in the same cycle as its inputs change.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    typedef enum logic [1:0] {
        MODE_UNS   = 2'd0,
        MODE_MIXED = 2'd1,
        MODE_SGN   = 2'd2,
        MODE_FRAC  = 2'd3
    } mode_e;

    function automatic mode_e pick_mode(input logic sa, input logic sb,
                                        input logic rnd, input logic sat);
        if (sa && sb)
            return (rnd || sat) ? MODE_FRAC : MODE_SGN;
        else if (sa || sb)
            return MODE_MIXED;
        else
            return MODE_UNS;
    endfunction

endpackage

// File: rtl/dsm_in_stage.sv
module dsm_in_stage #(
    parameter int A_W     = 18,
    parameter int B_W     = 18,
    parameter bit USE_REG = 1'b1
) (
    input  logic           clk,
    input  logic           clr,
    input  logic           en,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    input  logic           sa_i,
    input  logic           sb_i,
    input  logic           rnd_i,
    input  logic           sat_i,
    output logic [A_W-1:0] a_o,
    output logic [B_W-1:0] b_o,
    output logic           sa_o,
    output logic           sb_o,
    output logic           rnd_o,
    output logic           sat_o
);

    generate
        if (USE_REG) begin : g_reg
            always_ff @(posedge clk or posedge clr) begin
                if (clr) begin
                    a_o   <= '0;
                    b_o   <= '0;
                    sa_o  <= 1'b0;
                    sb_o  <= 1'b0;
                    rnd_o <= 1'b0;
                    sat_o <= 1'b0;
                end else if (en) begin
                    a_o   <= a_i;
                    b_o   <= b_i;
                    sa_o  <= sa_i;
                    sb_o  <= sb_i;
                    rnd_o <= rnd_i;
                    sat_o <= sat_i;
                end
            end
        end else begin : g_wire
            logic unused_wire;
            assign unused_wire = ^{clk, clr, en};
            always_comb begin
                a_o   = a_i;
                b_o   = b_i;
                sa_o  = sa_i;
                sb_o  = sb_i;
                rnd_o = rnd_i;
                sat_o = sat_i;
            end
        end
    endgenerate

endmodule

// File: rtl/dsm_mult_core.sv
module dsm_mult_core #(
    parameter int A_W = 18,
    parameter int B_W = 18,
    localparam int P_W = A_W + B_W
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    input  logic           sa,
    input  logic           sb,
    output logic [P_W-1:0] p
);

    // One extra top bit per operand: a copy of the sign when signed, zero otherwise.
    logic signed [A_W:0]     ext_a;
    logic signed [B_W:0]     ext_b;
    logic signed [P_W+1:0]   full;

    always_comb begin
        ext_a = $signed({sa & a[A_W-1], a});
        ext_b = $signed({sb & b[B_W-1], b});
        full  = ext_a * ext_b;
        p     = full[P_W-1:0];
    end

endmodule

// File: rtl/dsm_round_sat.sv
module dsm_round_sat
    import dsm_pkg::*;
#(
    parameter int P_W = 36,
    parameter int Q_W = 16,
    localparam int FRAC_W = Q_W - 1,
    localparam int QL     = P_W + 1 - FRAC_W
) (
    input  logic [P_W-1:0] p,
    input  mode_e          mode,
    input  logic           rnd,
    input  logic           sat,
    output logic [P_W-1:0] res,
    output logic           flag
);

    localparam logic [P_W:0]       HALF_V = (P_W+1)'(1) << (FRAC_W - 1);
    localparam int                 QMAX_I = (1 << (Q_W - 1)) - 1;
    localparam logic signed [QL-1:0] Q_HI = QL'(QMAX_I);
    localparam logic signed [QL-1:0] Q_LO = QL'(-QMAX_I - 1);

    logic [P_W:0]           rsum;
    logic signed [QL-1:0]   q;
    logic                   over_hi;
    logic                   over_lo;
    logic [Q_W-1:0]         qval;

    always_comb begin
        rsum    = {p[P_W-1], p} + (rnd ? HALF_V : '0);
        q       = $signed(rsum[P_W:FRAC_W]);
        over_hi = q > Q_HI;
        over_lo = q < Q_LO;
        qval    = q[Q_W-1:0];
        res     = p;
        flag    = 1'b0;
        unique case (mode)
            MODE_FRAC: begin
                if (sat && over_hi) begin
                    qval = Q_HI[Q_W-1:0];
                    flag = 1'b1;
                end else if (sat && over_lo) begin
                    qval = Q_LO[Q_W-1:0];
                    flag = 1'b1;
                end
                res = {{(P_W-Q_W){qval[Q_W-1]}}, qval};
            end
            MODE_UNS, MODE_MIXED, MODE_SGN: begin
                res  = p;
                flag = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dsm_out_stage.sv
module dsm_out_stage #(
    parameter int P_W     = 36,
    parameter bit USE_REG = 1'b1
) (
    input  logic           clk,
    input  logic           clr,
    input  logic           en,
    input  logic [P_W-1:0] d,
    input  logic           d_flag,
    output logic [P_W-1:0] q,
    output logic           q_flag
);

    generate
        if (USE_REG) begin : g_reg
            always_ff @(posedge clk or posedge clr) begin
                if (clr) begin
                    q      <= '0;
                    q_flag <= 1'b0;
                end else if (en) begin
                    q      <= d;
                    q_flag <= d_flag;
                end
            end
        end else begin : g_wire
            logic unused_wire;
            assign unused_wire = ^{clk, clr, en};
            always_comb begin
                q      = d;
                q_flag = d_flag;
            end
        end
    endgenerate

endmodule

// File: rtl/dynsign_mult.sv
module dynsign_mult
    import dsm_pkg::*;
#(
    parameter int A_W     = 18,
    parameter int B_W     = 18,
    parameter int Q_W     = 16,
    parameter bit IN_REG  = 1'b1,
    parameter bit OUT_REG = 1'b1,
    localparam int P_W = A_W + B_W
) (
    input  logic           clk,
    input  logic           in_clr,
    input  logic           in_en,
    input  logic           out_clr,
    input  logic           out_en,
    input  logic [A_W-1:0] op_a,
    input  logic [B_W-1:0] op_b,
    input  logic           a_signed,
    input  logic           b_signed,
    input  logic           rnd_en,
    input  logic           sat_en,
    output logic [P_W-1:0] prod,
    output logic           sat_flag
);

    logic [A_W-1:0] st_a;
    logic [B_W-1:0] st_b;
    logic           st_sa;
    logic           st_sb;
    logic           st_rnd;
    logic           st_sat;
    mode_e          st_mode;
    logic [P_W-1:0] core_prod;
    logic [P_W-1:0] core_res;
    logic           core_flag;

    dsm_in_stage #(.A_W(A_W), .B_W(B_W), .USE_REG(IN_REG)) u_in (
        .clk   (clk),
        .clr   (in_clr),
        .en    (in_en),
        .a_i   (op_a),
        .b_i   (op_b),
        .sa_i  (a_signed),
        .sb_i  (b_signed),
        .rnd_i (rnd_en),
        .sat_i (sat_en),
        .a_o   (st_a),
        .b_o   (st_b),
        .sa_o  (st_sa),
        .sb_o  (st_sb),
        .rnd_o (st_rnd),
        .sat_o (st_sat)
    );

    always_comb st_mode = pick_mode(st_sa, st_sb, st_rnd, st_sat);

    dsm_mult_core #(.A_W(A_W), .B_W(B_W)) u_core (
        .a  (st_a),
        .b  (st_b),
        .sa (st_sa),
        .sb (st_sb),
        .p  (core_prod)
    );

    dsm_round_sat #(.P_W(P_W), .Q_W(Q_W)) u_rs (
        .p    (core_prod),
        .mode (st_mode),
        .rnd  (st_rnd),
        .sat  (st_sat),
        .res  (core_res),
        .flag (core_flag)
    );

    dsm_out_stage #(.P_W(P_W), .USE_REG(OUT_REG)) u_out (
        .clk    (clk),
        .clr    (out_clr),
        .en     (out_en),
        .d      (core_res),
        .d_flag (core_flag),
        .q      (prod),
        .q_flag (sat_flag)
    );

endmodule

// File: rtl/dynsign_mult_chk.sv
module dynsign_mult_chk
    import dsm_pkg::*;
#(
    parameter int P_W     = 36,
    parameter int Q_W     = 16,
    parameter bit OUT_REG = 1'b1
) (
    input logic           clk,
    input logic           in_clr,
    input logic           out_clr,
    input logic           out_en,
    input logic [P_W-1:0] prod,
    input logic           sat_flag,
    input mode_e          s_mode,
    input logic           s_sat,
    input logic [P_W-1:0] c_res,
    input logic           c_flag
);

    localparam logic [P_W-1:0] CLAMP_HI = P_W'((1 << (Q_W - 1)) - 1);
    localparam logic [P_W-1:0] CLAMP_LO = ~CLAMP_HI;

    // R8: a flagged output carries one of the two clamp values
    a_r8_flag_clamped: assert property (@(posedge clk) disable iff (in_clr || out_clr)
        sat_flag |-> (prod == CLAMP_HI || prod == CLAMP_LO));

    // R9: the flag can only come from fractional mode with saturation on
    a_r9_flag_needs_frac: assert property (@(posedge clk) disable iff (in_clr || out_clr)
        c_flag |-> (s_mode == MODE_FRAC && s_sat));

    // R6: the fractional result is a sign-extended 16-bit value
    a_r6_frac_sext: assert property (@(posedge clk) disable iff (in_clr || out_clr)
        (s_mode == MODE_FRAC) |-> (c_res[P_W-1:Q_W-1] == '0 || c_res[P_W-1:Q_W-1] == '1));

    generate
        if (OUT_REG) begin : g_out_chk
            // R4: a disabled result stage holds its value
            a_r4_out_hold: assert property (@(posedge clk) disable iff (in_clr || out_clr)
                !out_en |=> ($stable(prod) && $stable(sat_flag)));

            // R5: a clear forces a zero result
            a_r5_out_clear: assert property (@(posedge clk)
                out_clr |-> (prod == '0 && !sat_flag));
        end
    endgenerate

endmodule

bind dynsign_mult dynsign_mult_chk #(.P_W(P_W), .Q_W(Q_W), .OUT_REG(OUT_REG)) u_chk (
    .clk      (clk),
    .in_clr   (in_clr),
    .out_clr  (out_clr),
    .out_en   (out_en),
    .prod     (prod),
    .sat_flag (sat_flag),
    .s_mode   (st_mode),
    .s_sat    (st_sat),
    .c_res    (core_res),
    .c_flag   (core_flag)
);

// File: tb/dynsign_mult_test.sv
`timescale 1ns/1ps
module dynsign_mult_test;

    logic        clk = 1'b0;
    logic        in_clr, in_en, out_clr, out_en;
    logic [17:0] op_a, op_b;
    logic        a_signed, b_signed, rnd_en, sat_en;
    logic [35:0] prod, prod_c;
    logic        sat_flag, flag_c;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [35:0] res;
        logic        flag;
        int          due;
        string       req;
    } item_t;
    item_t sbq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dynsign_mult uut (
        .clk(clk), .in_clr(in_clr), .in_en(in_en), .out_clr(out_clr), .out_en(out_en),
        .op_a(op_a), .op_b(op_b), .a_signed(a_signed), .b_signed(b_signed),
        .rnd_en(rnd_en), .sat_en(sat_en), .prod(prod), .sat_flag(sat_flag)
    );

    dynsign_mult #(.IN_REG(1'b0), .OUT_REG(1'b0)) uut_comb (
        .clk(clk), .in_clr(in_clr), .in_en(in_en), .out_clr(out_clr), .out_en(out_en),
        .op_a(op_a), .op_b(op_b), .a_signed(a_signed), .b_signed(b_signed),
        .rnd_en(rnd_en), .sat_en(sat_en), .prod(prod_c), .sat_flag(flag_c)
    );

    task automatic chk36(input string req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s prod act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s flag act=%b exp=%b", req, act, exp);
        end
    endtask

    // Reference model written from the requirements
    task automatic model(input logic [17:0] a, input logic [17:0] b,
                         input logic sa, input logic sb, input logic rnd, input logic sat,
                         output logic [35:0] res, output logic flag);
        longint va, vb, p, qq;
        logic [15:0] q16;
        va = sa ? longint'($signed(a)) : longint'(a);
        vb = sb ? longint'($signed(b)) : longint'(b);
        p = va * vb;
        flag = 1'b0;
        if (sa && sb && (rnd || sat)) begin
            qq = (p + (rnd ? 64'sd16384 : 64'sd0)) >>> 15;
            if (sat && qq > 32767) begin
                qq = 32767;
                flag = 1'b1;
            end else if (sat && qq < -32768) begin
                qq = -32768;
                flag = 1'b1;
            end
            q16 = qq[15:0];
            res = {{20{q16[15]}}, q16};
        end else begin
            res = p[35:0];
        end
    endtask

    task automatic issue(input logic [17:0] a, input logic [17:0] b,
                         input logic sa, input logic sb, input logic rnd, input logic sat,
                         input string req);
        logic [35:0] er;
        logic        ef;
        item_t       it;
        @(negedge clk);
        op_a = a; op_b = b; a_signed = sa; b_signed = sb; rnd_en = rnd; sat_en = sat;
        model(a, b, sa, sb, rnd, sat, er, ef);
        it.res = er; it.flag = ef; it.due = cyc + 2; it.req = req;
        sbq.push_back(it);
        #1;
        // R3: zero-latency variant follows its inputs in the same cycle
        chk36({"R3 comb ", req}, prod_c, er);
        chk1({"R3 comb ", req}, flag_c, ef);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        item_t it;
        if (sbq.size() > 0 && sbq[0].due == cyc) begin
            it = sbq.pop_front();
            chk36(it.req, prod, it.res);
            chk1(it.req, sat_flag, it.flag);
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [35:0] er;
        logic        ef;
        in_clr = 1'b1; out_clr = 1'b1; in_en = 1'b1; out_en = 1'b1;
        op_a = '0; op_b = '0; a_signed = 1'b0; b_signed = 1'b0; rnd_en = 1'b0; sat_en = 1'b0;
        #1;
        chk36("R5 reset", prod, 36'h0);
        chk1("R5 reset", sat_flag, 1'b0);
        repeat (2) @(negedge clk);
        in_clr = 1'b0; out_clr = 1'b0;

        // R1 / R2 basic products
        issue(18'h3FFFF, 18'h3FFFF, 0, 0, 0, 0, "R1 max unsigned");
        issue(18'h3FFFF, 18'h3FFFF, 1, 1, 0, 0, "R2 signed -1*-1");
        issue(18'h3FFFF, 18'h3FFFF, 1, 0, 0, 0, "R2 mixed a signed");
        issue(18'h3FFFF, 18'h00003, 0, 1, 0, 0, "R2 mixed b signed");
        issue(18'h20000, 18'h20000, 1, 1, 0, 0, "R2 min*min");
        // R3 sign select switches every cycle on the same operands
        issue(18'h20001, 18'h1FFFF, 0, 0, 0, 0, "R3 switch uu");
        issue(18'h20001, 18'h1FFFF, 1, 1, 0, 0, "R3 switch ss");
        issue(18'h20001, 18'h1FFFF, 1, 0, 0, 0, "R3 switch su");
        // R6 / R7 / R8 fractional mode
        issue(18'h38000, 18'h38000, 1, 1, 0, 1, "R8 -1*-1 clamps");
        issue(18'h38000, 18'h38000, 1, 1, 1, 0, "R6 -1*-1 wraps no sat");
        issue(18'h38000, 18'h38000, 1, 1, 1, 1, "R8 -1*-1 round+sat");
        issue(18'h04000, 18'h00001, 1, 1, 1, 0, "R7 half rounds up");
        issue(18'h04000, 18'h00001, 1, 1, 0, 1, "R6 half truncates");
        issue(18'h3C000, 18'h00001, 1, 1, 0, 1, "R6 neg truncates");
        issue(18'h3C000, 18'h00001, 1, 1, 1, 0, "R7 neg rounds");
        issue(18'h07FFF, 18'h07FFF, 1, 1, 1, 1, "R8 max no clamp");
        // R9 controls ignored outside fractional mode
        issue(18'h38000, 18'h38000, 1, 0, 1, 1, "R9 mixed ignores rnd/sat");
        issue(18'h38000, 18'h38000, 0, 0, 1, 1, "R9 unsigned ignores rnd/sat");
        issue(18'h12345, 18'h0ABCD, 1, 1, 0, 0, "R9 signed no controls");

        for (int i = 0; i < 60; i++) begin
            logic [31:0] ra, rb, rm;
            ra = $urandom; rb = $urandom; rm = $urandom;
            if (rm[3:2] == 2'd3)
                issue({{2{ra[15]}}, ra[15:0]}, {{2{rb[15]}}, rb[15:0]}, 1, 1, rm[0], rm[1], "R6 random frac");
            else
                issue(ra[17:0], rb[17:0], rm[0], rm[1], rm[4], rm[5], "R2 random");
        end
        repeat (4) @(negedge clk);

        // R4 hold behaviour
        issue(18'h00123, 18'h00456, 0, 0, 0, 0, "R4 preload");
        repeat (4) @(negedge clk);
        out_en = 1'b0;
        op_a = 18'h3FFFF; op_b = 18'h00002; a_signed = 1'b1; b_signed = 1'b0;
        rnd_en = 1'b0; sat_en = 1'b0;
        repeat (3) @(negedge clk);
        model(18'h00123, 18'h00456, 0, 0, 0, 0, er, ef);
        chk36("R4 out_en low holds", prod, er);
        in_en = 1'b0; out_en = 1'b1;
        op_a = 18'h00005; op_b = 18'h00007; a_signed = 1'b0;
        @(negedge clk);
        chk36("R4 in_en low keeps staged operands", prod, 36'hF_FFFF_FFFE);
        repeat (2) @(negedge clk);
        chk36("R4 in_en low still held", prod, 36'hF_FFFF_FFFE);

        // R5 asynchronous clears
        #1 out_clr = 1'b1;
        #0.5;
        chk36("R5 out_clr immediate", prod, 36'h0);
        chk1("R5 out_clr flag", sat_flag, 1'b0);
        out_clr = 1'b0;
        @(negedge clk);
        chk36("R5 reload after out_clr", prod, 36'hF_FFFF_FFFE);
        #1 in_clr = 1'b1;
        #0.5 in_clr = 1'b0;
        @(negedge clk);
        chk36("R5 in_clr zeroes operands", prod, 36'h0);
        in_en = 1'b1;

        // R8 flag only in the clamped cycle, back to back
        issue(18'h38000, 18'h38000, 1, 1, 0, 1, "R8 clamp again");
        issue(18'h38000, 18'h08000, 1, 1, 0, 1, "R8 next cycle no flag");
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule